// File: doc/BRIEF.md
# Set-Associative LRU Tag Lookup

This block models the tag side of a set-associative cache. It has no data storage. A client presents a byte address and an access size of 1 up to a parameterised maximum. The block then answers with one bit that says whether the access hit or missed. Every set keeps its resident tags in strict recency order. A hit promotes the matching tag to the most-recent slot. A miss inserts the new tag there and drops the least-recent one, whether the access is a load or a store.

When the bytes of an access run past the end of one line into the following line, the block looks up both sets, one cycle each. It then returns a single combined answer. An access whose last byte lands in a set that is neither the first set nor the one after it cannot be modelled. Such an access gets an error response and leaves the stored state untouched.

Top module: `lru_tag_cache`

## Requirements
- R1: The set count is CACHE_BYTES / LINE_BYTES / WAYS. The set index is the address bits immediately above the log2(LINE_BYTES) offset bits. The tag is the address shifted right by log2(LINE_BYTES) + log2(sets).
- R2: After reset every entry is invalid, so the first access to any line reports a miss. After reset `req_ready` is 1 and `resp_valid` is 0.
- R3: A lookup that finds its tag at recency position p reports a hit. It moves that tag to position 0, and positions 0..p-1 each move down by one.
- R4: A lookup that misses writes the tag at position 0, moves every entry down by one, and discards the entry in position WAYS-1.
- R5: An access whose first and last bytes share a set is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its response appears with `resp_valid`=1 for one cycle after the next edge.
- R6: An access whose last byte falls in set (first set + 1) mod sets is a straddling access. `req_ready` is 0 for one cycle after acceptance and no response is issued in that cycle. The single response follows one cycle later.
- R7: The response of a straddling access is a hit only if both lookups hit. Both sets are updated as in R3/R4.
- R8: The second lookup of a straddling access uses the tag of the last-byte address. When the first set is the last set, that tag is one greater than the first tag.
- R9: If the last-byte set is neither the first set nor the next set, the response has `resp_err`=1 and `resp_hit`=0, and no set changes.
- R10: While `req_valid` is 0 and no straddling access is pending, no response is issued and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | SIZE_W | Access length in bytes, 1..MAX_SIZE |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 = hit, 0 = miss (or error) |
| resp_err | output | 1 | Access spans more than two consecutive sets |

## Verification
The hardest case to reach from the ports is a straddling access whose first line sits in the last set. Here the second lookup wraps to set 0 with an incremented tag, and it must be checked against a set whose recency order has already been driven into a known state. The bench gets there with a full sweep of every start address in a small window against every size. This sweep covers wrapping, straddling and over-long accesses in every alignment. Directed fills before the sweep load each set to full occupancy, so that later hits and evictions depend on exact recency order. A reference recency model inside the bench predicts each answer.

// File: rtl/lru_tag_cache.sv
module lru_tag_cache #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 128,
  parameter int LINE_BYTES  = 8,
  parameter int WAYS        = 4,
  parameter int MAX_SIZE    = 16,
  parameter int SIZE_W      = $clog2(MAX_SIZE) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_err
);
  localparam int SETS  = CACHE_BYTES / LINE_BYTES / WAYS;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic             vld_q [SETS][WAYS];

  logic             busy_q, hit1_q;
  logic [IDX_W-1:0] set2_q;
  logic [TAG_W-1:0] tag2_q;
  logic             resp_valid_q, resp_hit_q, resp_err_q;

  logic [ADDR_W-1:0] last_addr;
  logic [IDX_W-1:0]  set_a, set_b, set_nxt, cur_set;
  logic [TAG_W-1:0]  tag_a, tag_b, cur_tag;
  logic              accept, same_set, next_set, bad_span, lk_en;
  logic [WAYS-1:0]   hit_vec;
  logic              hit_any;
  logic [WAY_W-1:0]  hit_pos;

  assign req_ready  = !busy_q;
  assign accept     = req_valid && req_ready;
  assign last_addr  = req_addr + ADDR_W'(req_size) - ADDR_W'(1);
  assign set_a      = req_addr[OFF_W +: IDX_W];
  assign set_b      = last_addr[OFF_W +: IDX_W];
  assign tag_a      = req_addr[ADDR_W-1 -: TAG_W];
  assign tag_b      = last_addr[ADDR_W-1 -: TAG_W];
  assign set_nxt    = set_a + IDX_W'(1);
  assign same_set   = (set_a == set_b);
  assign next_set   = !same_set && (set_nxt == set_b);
  assign bad_span   = !same_set && !next_set;
  assign cur_set    = busy_q ? set2_q : set_a;
  assign cur_tag    = busy_q ? tag2_q : tag_a;
  assign lk_en      = busy_q || (accept && !bad_span);

  always_comb begin
    hit_pos = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      hit_vec[w] = vld_q[cur_set][w] && (tag_q[cur_set][w] == cur_tag);
      if (hit_vec[w]) hit_pos = WAY_W'(w);
    end
    hit_any = |hit_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
        end
    end else if (lk_en) begin
      tag_q[cur_set][0] <= cur_tag;
      vld_q[cur_set][0] <= 1'b1;
      for (int w = 1; w < WAYS; w++)
        if (!hit_any || w <= int'(hit_pos)) begin
          tag_q[cur_set][w] <= tag_q[cur_set][w-1];
          vld_q[cur_set][w] <= vld_q[cur_set][w-1];
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      hit1_q       <= 1'b0;
      set2_q       <= '0;
      tag2_q       <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_err_q   <= 1'b0;
    end else begin
      resp_valid_q <= busy_q || (accept && !next_set);
      resp_err_q   <= accept && bad_span;
      resp_hit_q   <= busy_q ? (hit1_q && hit_any) : (accept && !bad_span && hit_any);
      if (accept) begin
        busy_q <= next_set;
        hit1_q <= hit_any;
        set2_q <= set_b;
        tag2_q <= tag_b;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign resp_err   = resp_err_q;

  AST_MRU_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> (vld_q[$past(cur_set)][0] && tag_q[$past(cur_set)][0] == $past(cur_tag))); // R3
  AST_SINGLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && same_set) |=> (resp_valid && !resp_err)); // R5
  AST_STRADDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && next_set) |=> (!req_ready && !resp_valid)); // R6
  AST_STRADDLE_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (resp_valid && req_ready)); // R6
  AST_ERR_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_valid && !resp_hit)); // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !busy_q) |=> !resp_valid); // R10
endmodule

// File: tb/lru_tag_cache_bench.sv
module lru_tag_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 8;
  localparam int NSET = 4;
  localparam int NWAY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_size = 5'd1;
  logic        resp_valid, resp_hit, resp_err;

  int checks = 0;
  int errors = 0;
  int mdl [NSET][NWAY];

  always #(CLK_PERIOD/2) clk = ~clk;

  lru_tag_cache u_lru_tag_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_err(resp_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit mdl_lookup(input int s, input int t);
    int pos = -1;
    for (int w = 0; w < NWAY; w++) if (pos < 0 && mdl[s][w] == t) pos = w;
    if (pos < 0) pos = NWAY - 1;
    for (int w = pos; w > 0; w--) mdl[s][w] = mdl[s][w-1];
    mdl[s][0] = t;
    return (pos < NWAY - 1) || (mdl[s][0] == t && pos >= 0 && 0 == 1);
  endfunction

  function automatic bit mdl_probe(input int s, input int t);
    for (int w = 0; w < NWAY; w++) if (mdl[s][w] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic access(input int addr, input int size, input string req);
    int l1 = addr / LINE;
    int l2 = (addr + size - 1) / LINE;
    int s1 = l1 % NSET, t1 = l1 / NSET;
    int s2 = l2 % NSET, t2 = l2 / NSET;
    bit h1, h2;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'(addr); req_size = 5'(size);
    check(req_ready == 1'b1, "R5 ready before accept", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (s1 == s2) begin
      h1 = mdl_probe(s1, t1);
      void'(mdl_lookup(s1, t1));
      check(resp_valid && !resp_err, {req, " R5 single response"}, int'({resp_valid, resp_err}), 2);
      check(resp_hit == h1, {req, " R3/R4 single hit"}, int'(resp_hit), int'(h1));
    end else if ((s1 + 1) % NSET == s2) begin
      h1 = mdl_probe(s1, t1);
      void'(mdl_lookup(s1, t1));
      h2 = mdl_probe(s2, t2);
      void'(mdl_lookup(s2, t2));
      check(!resp_valid && !req_ready, {req, " R6 straddle hold"}, int'({resp_valid, req_ready}), 0);
      @(negedge clk);
      check(resp_valid && !resp_err, {req, " R6 straddle response"}, int'({resp_valid, resp_err}), 2);
      check(resp_hit == (h1 && h2), {req, (s1 == NSET-1) ? " R8 wrap straddle hit" : " R7 straddle hit"},
            int'(resp_hit), int'(h1 && h2));
    end else begin
      check(resp_valid && resp_err && !resp_hit, {req, " R9 error response"},
            int'({resp_valid, resp_err, resp_hit}), 6);
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSET; s++) for (int w = 0; w < NWAY; w++) mdl[s][w] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(req_ready == 1'b1, "R2 reset ready", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R2 reset no response", int'(resp_valid), 0);

    for (int l = 0; l < 16; l++) access(l * LINE, 1, "R2 R1 first touch");
    for (int l = 0; l < 16; l++) access(l * LINE + 3, 2, "R3 refill hit");
    access(2 * LINE, 1, "R3 promote");
    for (int l = 16; l < 20; l++) access(l * LINE, 4, "R4 evict");
    access(0, 1, "R4 evicted line");
    access(2 * LINE, 8, "R3 promoted survives");

    access(6, 4, "R7 straddle");
    access(3 * LINE + 7, 2, "R8 wrap");
    access(4, 16, "R9 span three");
    access(1 * LINE + 1, 1, "R9 unchanged after error");

    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      req_addr = 32'(200 + k * 8); req_size = 5'd1;
      check(resp_valid == 1'b0 && req_ready, "R10 idle", int'(resp_valid), 0);
    end
    access(200, 1, "R10 idle left state");

    for (int a = 0; a < 64; a++)
      for (int sz = 1; sz <= 16; sz++) access(a, sz, "R1 sweep");
    for (int i = 0; i < 1500; i++) access((i * 37 + 11) % 320, (i * 7) % 16 + 1, "R1 scatter");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule